// File: doc/BRIEF.md
# SM3 SS1 Vector Instruction Unit

This block executes a single vector instruction: the SS1 intermediate step of the SM3 hash compression function. It takes one 32-bit instruction word, checks its fixed opcode bits, and reads three source operands from a 32-entry register file of 128-bit vectors. It computes a 32-bit result from the most significant lane of each source and writes a 128-bit value back to a destination register. Only the top lane of that value carries data.

The arithmetic has three stages. The first source's top lane is rotated left by 12. That value is added modulo 2^32 to the top lanes of the second and third sources. The sum is then rotated left by 7. The unit accepts one instruction strobe per cycle. The register file is updated on the clock edge that samples the strobe, and a `done` pulse (or an `undef` pulse for a rejected word) appears in the following cycle. This latency is the same for every operand value.

A separate test write port loads the register file before or between instructions. A test read port exposes any register so that its contents can be observed. A `feat_en` input gates the whole instruction: when it is low, every strobed word is rejected.

Top module: `sm3v_unit`

## Requirements
- R1: While `rst` is high, `done` and `undef` are low in the following cycle. Reset does not change register contents.
- R2: A word is accepted only if bits [31:21] equal 11001110010 and bit [15] is 0. The index fields are: destination in bits [4:0], first source in [9:5], third source in [14:10] and second source in [20:16]. `wb_idx` reports the destination index.
- R3: Result bits [127:96] equal rol7((rol12(first[127:96]) + second[127:96] + third[127:96]) mod 2^32).
- R4: Result bits [95:0] are always zero, whatever the sources hold in their lower bits.
- R5: For an accepted strobe, `done` is high for exactly the next cycle, with `wb_data` equal to the result. In that same cycle the test read port shows the result in the destination register. The delay does not depend on operand values.
- R6: When `feat_en` is low, a strobed word with a matching opcode raises `undef` in the next cycle, keeps `done` low and writes no register.
- R7: A strobed word whose fixed bits do not match raises `undef` in the next cycle, keeps `done` low and writes no register.
- R8: The destination may equal any or all of the sources. The result is always computed from the register values held before the write.
- R9: In a cycle with no strobe, the next cycle has `done` and `undef` low and no register changes.
- R10: If a test write and an instruction result target the same register on the same edge, the instruction result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output flags |
| feat_en | input | 1 | Feature enable; when low, every strobed word is rejected |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| tw_en | input | 1 | Test write enable |
| tw_idx | input | 5 | Test write register index |
| tw_data | input | 128 | Test write data |
| dbg_idx | input | 5 | Test read register index |
| dbg_data | output | 128 | Test read data (combinational) |
| done | output | 1 | One-cycle pulse: result written |
| undef | output | 1 | One-cycle pulse: instruction rejected |
| wb_idx | output | 5 | Destination index of the last accepted instruction |
| wb_data | output | 128 | Result value of the last accepted instruction |

## Verification
The hardest situation to reach is a destination that aliases one or all of the sources. A wrong ordering of read and write only shows up there, because the result must come from the old values. The bench preloads a single register, issues words whose four index fields all name it, and also issues a word where only the second source matches the destination. It then checks both `wb_data` and the register seen through the test read port. A second case that is hard to reach is a test write colliding with a result write on the same edge. The bench produces it by driving the test port and the instruction strobe in the same cycle.

// File: rtl/sm3v_pkg.sv
package sm3v_pkg;
    localparam int INSTR_W = 32;
    localparam int LANE_W  = 32;
    localparam int VEC_W   = 128;
    localparam int NREGS   = 32;
    localparam int IDX_W   = $clog2(NREGS);
    localparam int ROT_PRE  = 12;
    localparam int ROT_POST = 7;
    localparam logic [10:0] OPC_HI = 11'b11001110010;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef struct packed {
        logic hit;
        idx_t dst;
        idx_t src_n;
        idx_t src_m;
        idx_t src_a;
    } dec_t;

    typedef struct packed {
        logic done;
        logic undef;
        idx_t idx;
        vec_t data;
    } wb_t;

    function automatic lane_t rotl(lane_t x, int unsigned s);
        return (x << s) | (x >> (LANE_W - s));
    endfunction
endpackage

// File: rtl/sm3v_decode.sv
module sm3v_decode
    import sm3v_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    always_comb begin
        dec.hit   = (instr[31:21] == OPC_HI) && !instr[15];
        dec.src_m = instr[20:16];
        dec.src_a = instr[14:10];
        dec.src_n = instr[9:5];
        dec.dst   = instr[4:0];
    end
endmodule

// File: rtl/sm3v_regfile.sv
module sm3v_regfile
    import sm3v_pkg::*;
#(
    parameter int NRD = 4
) (
    input  logic clk,
    input  idx_t raddr [NRD],
    output vec_t rdata [NRD],
    input  logic tst_we,
    input  idx_t tst_wa,
    input  vec_t tst_wd,
    input  logic res_we,
    input  idx_t res_wa,
    input  vec_t res_wd
);
    vec_t mem [NREGS];

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end

    always_ff @(posedge clk) begin
        if (tst_we && !(res_we && (res_wa == tst_wa)))
            mem[tst_wa] <= tst_wd;
        if (res_we)
            mem[res_wa] <= res_wd;
    end
endmodule

// File: rtl/sm3v_ss1_core.sv
module sm3v_ss1_core
    import sm3v_pkg::*;
(
    input  vec_t vn,
    input  vec_t vm,
    input  vec_t va,
    output vec_t res
);
    lane_t pre, sum;

    always_comb begin
        pre = rotl(vn[VEC_W-1 -: LANE_W], ROT_PRE);
        sum = pre + vm[VEC_W-1 -: LANE_W] + va[VEC_W-1 -: LANE_W];
        res = {rotl(sum, ROT_POST), {(VEC_W-LANE_W){1'b0}}};
    end
endmodule

// File: rtl/sm3v_unit.sv
module sm3v_unit
    import sm3v_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                feat_en,
    input  logic                instr_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic                tw_en,
    input  logic [IDX_W-1:0]    tw_idx,
    input  logic [VEC_W-1:0]    tw_data,
    input  logic [IDX_W-1:0]    dbg_idx,
    output logic [VEC_W-1:0]    dbg_data,
    output logic                done,
    output logic                undef,
    output logic [IDX_W-1:0]    wb_idx,
    output logic [VEC_W-1:0]    wb_data
);
    localparam int NRD = 4;

    dec_t dec;
    idx_t raddr [NRD];
    vec_t rdata [NRD];
    vec_t result;
    logic go, reject;
    wb_t  wb_q;

    sm3v_decode u_dec (.instr(instr), .dec(dec));

    assign raddr[0] = dec.src_n;
    assign raddr[1] = dec.src_m;
    assign raddr[2] = dec.src_a;
    assign raddr[3] = dbg_idx;

    sm3v_regfile #(.NRD(NRD)) u_rf (
        .clk    (clk),
        .raddr  (raddr),
        .rdata  (rdata),
        .tst_we (tw_en),
        .tst_wa (tw_idx),
        .tst_wd (tw_data),
        .res_we (go),
        .res_wa (dec.dst),
        .res_wd (result)
    );

    sm3v_ss1_core u_core (
        .vn  (rdata[0]),
        .vm  (rdata[1]),
        .va  (rdata[2]),
        .res (result)
    );

    assign go     = instr_valid && feat_en && dec.hit;
    assign reject = instr_valid && !(feat_en && dec.hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_q.done  <= 1'b0;
            wb_q.undef <= 1'b0;
        end else begin
            wb_q.done  <= go;
            wb_q.undef <= reject;
        end
        if (go) begin
            wb_q.idx  <= dec.dst;
            wb_q.data <= result;
        end
    end

    assign done     = wb_q.done;
    assign undef    = wb_q.undef;
    assign wb_idx   = wb_q.idx;
    assign wb_data  = wb_q.data;
    assign dbg_data = rdata[3];
endmodule

// File: rtl/sm3v_unit_chk.sv
module sm3v_unit_chk
    import sm3v_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               feat_en,
    input logic               instr_valid,
    input logic [INSTR_W-1:0] instr,
    input logic               done,
    input logic               undef,
    input logic [IDX_W-1:0]   wb_idx,
    input logic [VEC_W-1:0]   wb_data
);
    logic opc_ok;
    assign opc_ok = (instr[31:21] == OPC_HI) && (instr[15] == 1'b0);

    // R1
    reset_flags_chk: assert property (@(posedge clk)
        rst |=> (!done && !undef));

    // R2
    dest_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && feat_en && opc_ok) |=> (wb_idx == $past(instr[4:0])));

    // R4
    low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (wb_data[VEC_W-LANE_W-1:0] == '0));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && feat_en && opc_ok) |=> (done && !undef));

    // R6
    feat_off_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !feat_en) |=> (undef && !done));

    // R7
    bad_opc_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !opc_ok) |=> (undef && !done));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> (!done && !undef));
endmodule

bind sm3v_unit sm3v_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .feat_en     (feat_en),
    .instr_valid (instr_valid),
    .instr       (instr),
    .done        (done),
    .undef       (undef),
    .wb_idx      (wb_idx),
    .wb_data     (wb_data)
);

// File: tb/sm3v_unit_bench.sv
module sm3v_unit_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         feat_en = 1'b1;
    logic         instr_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic         tw_en = 1'b0;
    logic [4:0]   tw_idx = '0;
    logic [127:0] tw_data = '0;
    logic [4:0]   dbg_idx = '0;
    logic [127:0] dbg_data;
    logic         done, undef;
    logic [4:0]   wb_idx;
    logic [127:0] wb_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sm3v_unit u_sm3v_unit (.*);

    localparam int NV = 6;
    // each entry: first, second, third top lanes
    localparam logic [95:0] VECS [NV] = '{
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        {32'h0000_0001, 32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C},
        {32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001},
        {32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0BAD_C0DE}
    };

    function automatic logic [31:0] rl(logic [31:0] x, int s);
        logic [63:0] d;
        d = {x, x} << s;
        return d[63:32];
    endfunction

    function automatic logic [127:0] model(logic [31:0] n, logic [31:0] m, logic [31:0] a);
        logic [31:0] t;
        t = rl(n, 12) + m + a;
        return {rl(t, 7), 96'h0};
    endfunction

    function automatic logic [31:0] enc(logic [4:0] d, logic [4:0] n, logic [4:0] m, logic [4:0] a);
        return {11'b11001110010, m, 1'b0, a, n, d};
    endfunction

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(logic [4:0] idx, logic [127:0] v);
        @(negedge clk);
        tw_en = 1'b1; tw_idx = idx; tw_data = v;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    task automatic issue(logic [31:0] w);
        @(negedge clk);
        instr_valid = 1'b1; instr = w;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic peek(logic [4:0] idx, output logic [127:0] v);
        dbg_idx = idx;
        #0.5;
        v = dbg_data;
    endtask

    initial begin
        logic [127:0] e, r, old;
        repeat (3) @(negedge clk);
        // R1: flags low under reset
        chk(!done && !undef, "R1", {126'b0, done, undef}, 128'h0);
        load(5'd6, {32'h5555_AAAA, 96'h1});
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        peek(5'd6, r);
        chk(r == {32'h5555_AAAA, 96'h1}, "R1 regs kept", r, {32'h5555_AAAA, 96'h1});
        // R9: idle
        @(negedge clk);
        chk(!done && !undef, "R9", {126'b0, done, undef}, 128'h0);

        for (int i = 0; i < NV; i++) begin
            load(5'd1, {VECS[i][95:64], 96'hFFFF_0000_FFFF_0000_1234_5678});
            load(5'd2, {VECS[i][63:32], 96'hA5A5_A5A5_0000_0001_8000_0000});
            load(5'd3, {VECS[i][31:0],  96'h0F0F_F0F0_DEAD_BEEF_0000_0000});
            e = model(VECS[i][95:64], VECS[i][63:32], VECS[i][31:0]);
            issue(enc(5'd4, 5'd1, 5'd2, 5'd3));
            chk(done && !undef, "R5 done", {126'b0, done, undef}, 128'h2);
            chk(wb_data[127:96] == e[127:96], "R3", wb_data, e);
            chk(wb_data[95:0] == 96'h0, "R4", wb_data, e);
            chk(wb_idx == 5'd4, "R2 idx", {123'b0, wb_idx}, 128'd4);
            peek(5'd4, r);
            chk(r == e, "R5 reg", r, e);
        end

        // R2: field positions with distinct registers
        load(5'd7,  {32'h0102_0304, 96'h0});
        load(5'd20, {32'h1111_0000, 96'h0});
        load(5'd13, {32'h0000_2222, 96'h0});
        e = model(32'h0102_0304, 32'h1111_0000, 32'h0000_2222);
        issue(enc(5'd30, 5'd7, 5'd20, 5'd13));
        chk(wb_data == e && wb_idx == 5'd30, "R2 fields", wb_data, e);
        peek(5'd30, r);
        chk(r == e, "R2 dest", r, e);

        // R8: all four indices alias one register
        load(5'd9, {32'h89AB_CDEF, 96'h77});
        e = model(32'h89AB_CDEF, 32'h89AB_CDEF, 32'h89AB_CDEF);
        issue(enc(5'd9, 5'd9, 5'd9, 5'd9));
        chk(wb_data == e, "R8 alias all", wb_data, e);
        peek(5'd9, r);
        chk(r == e, "R8 alias reg", r, e);
        // R8: destination equals second source only
        load(5'd10, {32'h0000_0010, 96'h0});
        load(5'd11, {32'h3000_0000, 96'h0});
        load(5'd12, {32'h0000_0005, 96'h0});
        e = model(32'h0000_0010, 32'h3000_0000, 32'h0000_0005);
        issue(enc(5'd11, 5'd10, 5'd11, 5'd12));
        chk(wb_data == e, "R8 dst=m", wb_data, e);

        // R6: feature disabled
        load(5'd5, {32'hCAFE_CAFE, 96'h5});
        peek(5'd5, old);
        feat_en = 1'b0;
        issue(enc(5'd5, 5'd1, 5'd2, 5'd3));
        chk(undef && !done, "R6 flags", {126'b0, done, undef}, 128'h1);
        peek(5'd5, r);
        chk(r == old, "R6 no write", r, old);
        feat_en = 1'b1;

        // R7: opcode bit 21 wrong, then bit 15 set
        issue(enc(5'd5, 5'd1, 5'd2, 5'd3) ^ 32'h0020_0000);
        chk(undef && !done, "R7 opc", {126'b0, done, undef}, 128'h1);
        issue(enc(5'd5, 5'd1, 5'd2, 5'd3) | 32'h0000_8000);
        chk(undef && !done, "R7 bit15", {126'b0, done, undef}, 128'h1);
        peek(5'd5, r);
        chk(r == old, "R7 no write", r, old);

        // R9: idle after rejects
        @(negedge clk);
        chk(!done && !undef, "R9 idle", {126'b0, done, undef}, 128'h0);
        peek(5'd5, r);
        chk(r == old, "R9 no write", r, old);

        // R10: test write collides with result write
        load(5'd14, {32'h0000_0003, 96'h0});
        e = model(32'h0000_0003, 32'h0000_0003, 32'h0000_0003);
        @(negedge clk);
        instr_valid = 1'b1; instr = enc(5'd15, 5'd14, 5'd14, 5'd14);
        tw_en = 1'b1; tw_idx = 5'd15; tw_data = {128{1'b1}};
        @(negedge clk);
        instr_valid = 1'b0; tw_en = 1'b0;
        peek(5'd15, r);
        chk(r == e, "R10 priority", r, e);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule